// File: doc/BRIEF.md
# SAR Conversion Sequencer with Serial Output

This block runs a 12-bit successive-approximation conversion and sends each result bit out on a serial line as soon as that bit is decided. A rising edge on the start strobe begins a conversion, but only while chip select is low. The block then presents a trial code to an external DAC and reads back a one-bit comparator verdict on every master-clock cycle. Starting from the most significant bit, it keeps or drops each trial bit according to that verdict.

A frame output goes low for a fixed thirteen clock cycles. While the frame is low, the serial data line is driven; outside it, the line is released to high impedance. Two format pins are captured when the conversion starts. One inverts the leading bit, which turns offset binary into two's complement. The other complements every bit on its way out.

The serial clock is the master clock passed straight through. An inverted copy of the master clock is also provided, so a host can align its start strobe to a known edge.

Top module: `sar_serial_seq`

## Requirements
- R1: A conversion is accepted at a rising master-clock edge where `start_i` is 1, `start_i` was 0 at the previous edge, and `cs_ni` is 0. At that edge `frame_no` goes to 0 and `sdo_oe_o` goes to 1, so a strobe raised just after a rising edge always gives a delay of one clock.
- R2: While `cs_ni` is 1, a start strobe is ignored. The frame stays high and `dac_o` keeps its value.
- R3: At the accepting edge the trial code becomes 0x800: the MSB is set and all lower bits are cleared.
- R4: On each decision, a 1 on `comp_i` (DAC value not above the input) keeps the trial bit, and a 0 clears it. The next lower bit is then set as the new trial. After the frame, `dac_o` holds the final result, which equals the input for an ideal comparator.
- R5: The MSB is decided and driven on `sdo_o` at the second rising edge after the strobe. Bit 11-k follows at edge k+2. Each bit stays stable across the falling edge that follows it.
- R6: `frame_no` stays 0 for exactly 13 clock cycles. At the 13th edge after the frame falls, `frame_no` returns to 1 and `sdo_oe_o` returns to 0.
- R7: A rising start strobe during a frame is ignored. The frame is neither lengthened nor restarted, the result is unchanged, and no frame follows.
- R8: The serial bit equals the decided bit XOR `cmpl_i`, and the MSB is also XORed with `twos_i`. Both pins are captured at the accepting edge, so changing them during a frame has no effect.
- R9: `sclk_o` equals the master clock and `clk_no` equals its inverse at all times.
- R10: While reset is asserted, `frame_no` is 1, `sdo_oe_o` is 0 and `dac_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| start_i | input | 1 | Conversion start strobe, rising edge |
| comp_i | input | 1 | Comparator verdict, 1 when DAC value does not exceed input |
| cmpl_i | input | 1 | 1 selects complemented output coding |
| twos_i | input | 1 | 1 selects two's complement (MSB inverted) |
| sclk_o | output | 1 | Continuous serial clock |
| clk_no | output | 1 | Inverted master clock |
| dac_o | output | 12 | Trial code to the DAC |
| sdo_o | output | 1 | Serial data, high impedance outside the frame |
| sdo_oe_o | output | 1 | Serial data drive enable |
| frame_no | output | 1 | Frame, low during conversion |

## Verification
The assertions assume that the start strobe and chip select change only away from a rising clock edge. They also assume that `comp_i` settles within one cycle of a new trial code and that the analog value is held for the whole frame. The bench drives every input on the falling edge. It models the comparator combinationally from `dac_o` and a value that it changes only between frames. The start strobe is raised in the middle of a frame only where the test needs that, to show the strobe is ignored.

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             start_i,
  input  logic             comp_i,
  input  logic             cmpl_i,
  input  logic             twos_i,
  output logic             sclk_o,
  output logic             clk_no,
  output logic [WIDTH-1:0] dac_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             frame_no
);
  localparam int CW = $clog2(WIDTH + 1);

  logic             start_q, busy, cmpl_q, twos_q, sdo_q;
  logic [CW-1:0]    cnt, bidx;
  logic [WIDTH-1:0] sar;
  logic             go;

  assign go   = start_i & ~start_q & ~cs_ni & ~busy;
  assign bidx = CW'(WIDTH - 1) - cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      sar     <= '0;
      cmpl_q  <= 1'b0;
      twos_q  <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      start_q <= start_i;
      if (go) begin
        busy   <= 1'b1;
        cnt    <= '0;
        sar    <= {1'b1, {(WIDTH-1){1'b0}}};
        cmpl_q <= cmpl_i;
        twos_q <= twos_i;
        sdo_q  <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(WIDTH)) begin
          busy <= 1'b0;
        end else begin
          cnt   <= cnt + 1'b1;
          sdo_q <= comp_i ^ cmpl_q ^ (twos_q & (cnt == '0));
          for (int i = 0; i < WIDTH; i++) begin
            if (CW'(i) == bidx)          sar[i] <= comp_i;
            else if (CW'(i + 1) == bidx) sar[i] <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o   = clk_i;
  assign clk_no   = ~clk_i;
  assign dac_o    = sar;
  assign sdo_oe_o = busy;
  assign sdo_o    = busy ? sdo_q : 1'bz;
  assign frame_no = ~busy;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             start_i,
  input logic             frame_no,
  input logic [WIDTH-1:0] dac_o
);
  int unsigned lowcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lowcnt <= 0;
    else if (!frame_no) lowcnt <= lowcnt + 1;
    else               lowcnt <= 0;
  end

  p_start_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> $past(start_i && !cs_ni));

  p_first_trial_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> dac_o == {1'b1, {(WIDTH-1){1'b0}}});

  p_frame_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> lowcnt == WIDTH + 1);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_no && $past(frame_no)) |-> $stable(dac_o));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .start_i (start_i),
  .frame_no(frame_no),
  .dac_o   (dac_o)
);

// File: tb/sim_sar_serial_seq.sv
module sim_sar_serial_seq;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, start = 1'b0;
  logic cmpl = 1'b0, twos = 1'b0;
  int   vin = 0;
  logic sclk, clk_n, sdo, sdo_oe, frame_n, comp;
  logic [11:0] dac;
  int errs = 0, checks = 0;
  bit done = 0;

  assign comp = (int'(dac) <= vin);

  always #2 clk = ~clk;

  sar_serial_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .start_i(start), .comp_i(comp),
    .cmpl_i(cmpl), .twos_i(twos), .sclk_o(sclk), .clk_no(clk_n), .dac_o(dac),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .frame_no(frame_n)
  );

  function automatic bit exp_bit(int v, bit c, bit t, int idx);
    return v[idx] ^ c ^ (t & (idx == 11));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic conv(int v, bit c, bit t, bit poke_start, bit poke_fmt);
    @(negedge clk);
    vin = v; cmpl = c; twos = t; cs_n = 0; start = 1;
    @(negedge clk);
    chk(frame_n == 0, "R1 frame low", frame_n, 0);
    chk(sdo_oe == 1, "R1 drive enabled", sdo_oe, 1);
    chk(dac == 12'h800, "R3 first trial", dac, 12'h800);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(frame_n == 0, "R6 frame held", frame_n, 0);
      chk(sdo == exp_bit(v, c, t, 11 - k), "R5 R8 serial bit", sdo, exp_bit(v, c, t, 11 - k));
      if (k == 0) start = 0;
      if (poke_start && k == 4) start = 1;
      if (poke_start && k == 5) start = 0;
      if (poke_fmt && k == 3) begin cmpl = ~c; twos = ~t; end
    end
    @(negedge clk);
    chk(frame_n == 1, "R6 frame end", frame_n, 1);
    chk(sdo_oe == 0, "R6 drive released", sdo_oe, 0);
    chk(int'(dac) == v, "R4 result", dac, v);
    if (poke_start) begin
      @(negedge clk);
      chk(frame_n == 1, "R7 no restart", frame_n, 1);
      chk(int'(dac) == v, "R7 result kept", dac, v);
    end
    cmpl = c; twos = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int r;
    r = int'($urandom(32'd29));
    repeat (3) @(negedge clk);
    chk(frame_n == 1, "R10 frame in reset", frame_n, 1);
    chk(sdo_oe == 0, "R10 drive in reset", sdo_oe, 0);
    chk(dac == 0, "R10 code in reset", dac, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sclk == 0 && clk_n == 1, "R9 low phase", {sclk, clk_n}, 1);
    @(posedge clk); #1;
    chk(sclk == 1 && clk_n == 0, "R9 high phase", {sclk, clk_n}, 2);

    conv(0, 0, 0, 0, 0);
    conv(4095, 0, 0, 0, 0);
    conv(2048, 0, 1, 0, 0);
    conv(2047, 1, 0, 0, 0);
    conv(1234, 1, 1, 0, 1);
    conv(3000, 0, 0, 1, 0);

    @(negedge clk);
    cs_n = 1; start = 1; vin = 55;
    repeat (3) begin
      @(negedge clk);
      chk(frame_n == 1, "R2 deselected", frame_n, 1);
      chk(dac == 12'd3000, "R2 code held", dac, 3000);
    end
    start = 0;
    @(negedge clk);
    cs_n = 0;

    for (int n = 0; n < 40; n++) begin
      int v = int'($urandom % 4096);
      bit c = 1'($urandom);
      bit t = 1'($urandom);
      conv(v, c, t, 0, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule